// File: doc/BRIEF.md
# Strobed Parallel Port Controller

This block is a bidirectional parallel data port meant to sit as a peripheral on a host processor's bus. The local CPU sees three registers through a simple one-cycle read/write interface: an output buffer (written by the CPU, driven onto the data pins), an input buffer (captured from the data pins, read by the CPU) and a configuration/status word. On the pin side there are the data lines with a single output-enable, an active-low output strobe, an active-low input strobe, and two general flag pins (A and B). Each flag pin can be a fixed level, a copy of one of the buffer-full flags, or an input.

The output strobe, the input strobe and flag B pass through a synchronizer of `SYNC_STAGES` flops before they drive any state. Edges are found on the synchronized copies, so all flag and buffer updates happen in the single clock domain. The driver-enable and the data/status select on the pins are combinational from the raw pins. A host bus can therefore gate the drivers without clock latency. With the reset configuration and every control pin tied low, the block behaves as a plain always-driven port whose input buffer follows the pins.

Top module: `strobed_pport`

## Requirements
- R1: After reset the configuration/status word reads 0xFC, both flag pins are inputs (output-enable low), and the data drivers are off while the output strobe is high.
- R2: The word is read with `regSel`=1. Bit 0 is the input-full flag and bit 1 is the output-full flag. A CPU write with `regSel`=1 updates bits 7..2 and leaves bits 1..0 unchanged.
- R3: A CPU write with `regSel`=0 loads the output buffer and sets the output-full flag. The flag is cleared by a synchronized output-strobe edge: the rising edge if bit 3 is 1, the falling edge if bit 3 is 0. A clear edge arrives 2 clocks after the pin changes. If a buffer write happens in that same cycle, the write wins.
- R4: With bit 2 at 0, the input buffer captures the data pins only on a rising edge of the input strobe, and that edge sets the input-full flag. A falling edge does neither.
- R5: With bit 2 at 1, the input buffer follows the data pins while the synchronized input strobe is low and holds while it is high. The falling edge sets the input-full flag.
- R6: A CPU read with `regSel`=0 returns the input buffer and clears the input-full flag. If a flag-setting strobe edge lands in the same cycle, the flag stays set.
- R7: When bits 7..6 are 11 (flag B as enable input) and flag B is high, input-strobe edges neither load the input buffer nor set the input-full flag.
- R8: When bits 7..6 are 11, `padOe` is high only while both the output strobe and flag B are low. For any other flag-B mode, `padOe` stays high (output-always) and the output strobe still clears the output-full flag.
- R9: When bits 5..4 are 11 and flag A is high, `padOut` carries the configuration/status word. Otherwise it carries the output buffer.
- R10: The mode of flag A is set by bits 5..4 and the mode of flag B by bits 7..6. The codes are: 00 drives low, 01 drives high, 10 drives the flag's mirror (output-full for A, input-full for B), 11 makes the pin an input with its output-enable low.
- R11: If the block is reset and run with all four control pins low, the drivers are on, an output-buffer write appears on `padOut`, and the input buffer follows `padIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 1 | Register select: 0 data buffers, 1 configuration/status |
| regWr | input | 1 | CPU write strobe, one cycle |
| regRd | input | 1 | CPU read strobe, one cycle (clears input-full on data read) |
| regWdata | input | DATA_W | CPU write data |
| regRdata | output | DATA_W | CPU read data, combinational from `regSel` |
| padIn | input | DATA_W | Data pin input values |
| padOut | output | DATA_W | Data pin output values |
| padOe | output | 1 | Data pin driver enable |
| outStbN | input | 1 | Output strobe, active low |
| inStbN | input | 1 | Input strobe, active low |
| flagAIn | input | 1 | Flag A pin input value |
| flagAOut | output | 1 | Flag A pin output value |
| flagAOe | output | 1 | Flag A pin driver enable |
| flagBIn | input | 1 | Flag B pin input value |
| flagBOut | output | 1 | Flag B pin output value |
| flagBOe | output | 1 | Flag B pin driver enable |

## Verification
The bench builds the block with an 8-bit data path and a two-flop synchronizer. At that width the status word maps bit for bit onto the data pins, so the status-on-pins select can be checked as an exact byte. The fixed two-clock strobe latency lets the bench place a buffer write exactly on an output-flag clear edge, and a buffer read exactly on an input-flag set edge, to test both priority rules. A reset with every control pin held low exercises the plain-port default.

// File: rtl/pport_pkg.sv
package pport_pkg;

  localparam int CSR_W = 8;

  typedef enum logic [1:0] {
    FLAG_LOW    = 2'b00,
    FLAG_HIGH   = 2'b01,
    FLAG_MIRROR = 2'b10,
    FLAG_INPUT  = 2'b11
  } flagMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic outLoad;  // load output buffer from CPU data
    logic inLoad;   // load input buffer from synchronized pins
    logic drvEn;    // data pin drivers on
    logic selCsr;   // drive status word instead of output buffer
  } dpCtl_t;

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int         W      = 1,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[0] <= RST;
        else       chain[0] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[s] <= RST;
        else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [CSR_W-1:2] cfgWdata,
  input  logic             odsSync,
  input  logic             idsSync,
  input  logic             bSync,
  input  logic             outStbN,
  input  logic             flagAIn,
  input  logic             flagBIn,
  output dpCtl_t           ctl,
  output logic [CSR_W-1:0] csr,
  output logic             flagAOut,
  output logic             flagAOe,
  output logic             flagBOut,
  output logic             flagBOe
);
  localparam int CFG_W = CSR_W - 2;

  logic [CFG_W-1:0] cfgQ;   // [0] input mode, [1] clear edge, [3:2] A, [5:4] B
  logic obfQ, ibfQ;
  logic odsPrev, idsPrev;

  flagMode_e aMode, bMode;
  logic inTransparent, clrOnRise;
  logic odsRise, odsFall, idsRise, idsFall;
  logic obfClr, inBlocked, inSet;
  logic outWr, cfgWr, bufRd;

  function automatic logic [1:0] flagDrive(flagMode_e m, logic mirror);
    unique case (m)
      FLAG_LOW:    return 2'b10;
      FLAG_HIGH:   return 2'b11;
      FLAG_MIRROR: return {1'b1, mirror};
      default:     return 2'b00;
    endcase
  endfunction

  always_comb begin
    aMode         = flagMode_e'(cfgQ[3:2]);
    bMode         = flagMode_e'(cfgQ[5:4]);
    inTransparent = cfgQ[0];
    clrOnRise     = cfgQ[1];
    odsRise       = odsSync & ~odsPrev;
    odsFall       = ~odsSync & odsPrev;
    idsRise       = idsSync & ~idsPrev;
    idsFall       = ~idsSync & idsPrev;
    obfClr        = clrOnRise ? odsRise : odsFall;
    inBlocked     = (bMode == FLAG_INPUT) && bSync;
    inSet         = !inBlocked && (inTransparent ? idsFall : idsRise);
    outWr         = regWr && !regSel;
    cfgWr         = regWr && regSel;
    bufRd         = regRd && !regSel;

    ctl.outLoad = outWr;
    ctl.inLoad  = !inBlocked && (inTransparent ? !idsSync : idsRise);
    ctl.drvEn   = (bMode != FLAG_INPUT) || (!outStbN && !flagBIn);
    ctl.selCsr  = (aMode == FLAG_INPUT) && flagAIn;

    {flagAOe, flagAOut} = flagDrive(aMode, obfQ);
    {flagBOe, flagBOut} = flagDrive(bMode, ibfQ);
    csr = {cfgQ, obfQ, ibfQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '1;
      obfQ    <= 1'b0;
      ibfQ    <= 1'b0;
      odsPrev <= 1'b1;
      idsPrev <= 1'b1;
    end else begin
      odsPrev <= odsSync;
      idsPrev <= idsSync;
      if (cfgWr) cfgQ <= cfgWdata;
      if (outWr)       obfQ <= 1'b1;
      else if (obfClr) obfQ <= 1'b0;
      if (inSet)       ibfQ <= 1'b1;
      else if (bufRd)  ibfQ <= 1'b0;
    end
  end
endmodule

// File: rtl/pport_dp.sv
module pport_dp
  import pport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] dataSync,
  input  logic [CSR_W-1:0]  csr,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] padOut,
  output logic              padOe
);
  logic [DATA_W-1:0] outBuf, inBuf, statusWord;

  assign statusWord = DATA_W'(csr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBuf <= '0;
      inBuf  <= '0;
    end else begin
      if (ctl.outLoad) outBuf <= regWdata;
      if (ctl.inLoad)  inBuf  <= dataSync;
    end
  end

  assign padOut   = ctl.selCsr ? statusWord : outBuf;
  assign padOe    = ctl.drvEn;
  assign regRdata = regSel ? statusWord : inBuf;
endmodule

// File: rtl/strobed_pport.sv
module strobed_pport
  import pport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOut,
  output logic              padOe,
  input  logic              outStbN,
  input  logic              inStbN,
  input  logic              flagAIn,
  output logic              flagAOut,
  output logic              flagAOe,
  input  logic              flagBIn,
  output logic              flagBOut,
  output logic              flagBOe
);
  localparam int CTL_W = 3;

  logic [CTL_W-1:0]  ctlSync;
  logic [DATA_W-1:0] dataSync;
  logic [CSR_W-1:0]  csrW;
  dpCtl_t            dpCtl;

  pport_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST({CTL_W{1'b1}})) uCtlSync (
    .clk(clk), .rstN(rstN), .din({outStbN, inStbN, flagBIn}), .dout(ctlSync)
  );

  pport_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST('0)) uDataSync (
    .clk(clk), .rstN(rstN), .din(padIn), .dout(dataSync)
  );

  pport_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .cfgWdata(regWdata[CSR_W-1:2]),
    .odsSync(ctlSync[2]), .idsSync(ctlSync[1]), .bSync(ctlSync[0]),
    .outStbN(outStbN), .flagAIn(flagAIn), .flagBIn(flagBIn),
    .ctl(dpCtl), .csr(csrW),
    .flagAOut(flagAOut), .flagAOe(flagAOe), .flagBOut(flagBOut), .flagBOe(flagBOe)
  );

  pport_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .regSel(regSel), .regWdata(regWdata),
    .dataSync(dataSync), .csr(csrW),
    .regRdata(regRdata), .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: rtl/pport_chk.sv
module pport_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regSel,
  input logic              regWr,
  input logic [DATA_W-1:0] regWdata,
  input logic [7:0]        csr,
  input logic              padOe,
  input logic              flagBIn,
  input logic              flagAOut
);
  a_r1_reset_word: assert property (@(posedge clk) $rose(rstN) |-> csr == 8'hFC);

  a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel) |=> csr[7:2] == $past(regWdata[7:2]));

  a_r3_obf_set: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regSel) |=> csr[1]);

  a_r8_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    (csr[7:6] == 2'b11 && flagBIn) |-> !padOe);

  a_r8_always_on: assert property (@(posedge clk) disable iff (!rstN)
    (csr[7:6] != 2'b11) |-> padOe);

  a_r10_a_mirror: assert property (@(posedge clk) disable iff (!rstN)
    (csr[5:4] == 2'b10) |-> flagAOut == csr[1]);
endmodule

bind strobed_pport pport_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
  .csr(csrW), .padOe(padOe), .flagBIn(flagBIn), .flagAOut(flagAOut)
);

// File: tb/sim_strobed_pport.sv
module sim_strobed_pport;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic          regSel = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [DW-1:0] regWdata = '0, padIn = '0;
  logic          outStbN = 1'b1, inStbN = 1'b1, flagAIn = 1'b0, flagBIn = 1'b0;
  logic [DW-1:0] regRdata, padOut;
  logic          padOe, flagAOut, flagAOe, flagBOut, flagBOe;

  strobed_pport #(.DATA_W(DW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .outStbN(outStbN), .inStbN(inStbN),
    .flagAIn(flagAIn), .flagAOut(flagAOut), .flagAOe(flagAOe),
    .flagBIn(flagBIn), .flagBOut(flagBOut), .flagBOe(flagBOe)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit modelOn = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {bit ods; bit ids; bit b; bit [DW-1:0] d;} smp_t;
  smp_t q[$];
  bit [5:0]    mHi;
  bit          mObf, mIbf;
  bit [DW-1:0] mObuf, mIbuf;

  function automatic smp_t idleSmp();
    smp_t s;
    s.ods = 1; s.ids = 1; s.b = 1; s.d = '0;
    return s;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mHi = 6'h3F; mObf = 0; mIbf = 0; mObuf = '0; mIbuf = '0;
      q.delete();
      for (int i = 0; i < 3; i++) q.push_back(idleSmp());
    end else begin
      smp_t now, cur, prv;
      bit clr, wr0, blocked, setIn;
      now.ods = outStbN; now.ids = inStbN; now.b = flagBIn; now.d = padIn;
      q.push_back(now);
      cur = q[q.size()-3];
      prv = q[q.size()-4];
      void'(q.pop_front());
      clr = mHi[1] ? (cur.ods && !prv.ods) : (!cur.ods && prv.ods);
      wr0 = regWr && !regSel;
      if (wr0) mObuf = regWdata;
      mObf = wr0 ? 1'b1 : (clr ? 1'b0 : mObf);
      blocked = (mHi[5:4] == 2'b11) && cur.b;
      setIn = 0;
      if (!blocked) begin
        if (!mHi[0]) begin
          if (cur.ids && !prv.ids) begin mIbuf = cur.d; setIn = 1; end
        end else begin
          if (!cur.ids) mIbuf = cur.d;
          if (!cur.ids && prv.ids) setIn = 1;
        end
      end
      if (setIn) mIbf = 1;
      else if (regRd && !regSel) mIbf = 0;
      if (regWr && regSel) mHi = regWdata[7:2];
    end
  end

  function automatic bit [1:0] flagExp(bit [1:0] m, bit mirror);
    case (m)
      2'b00: return 2'b10;
      2'b01: return 2'b11;
      2'b10: return {1'b1, mirror};
      default: return 2'b00;
    endcase
  endfunction

  always @(posedge clk) begin
    #5;
    if (rstN && modelOn) begin
      bit [7:0] eCsr;
      bit [1:0] fa, fb;
      eCsr = {mHi, mObf, mIbf};
      chk("R2 model rdata", regRdata, regSel ? eCsr : mIbuf);
      chk("R8 model padOe", padOe, (mHi[5:4] != 2'b11) || (!outStbN && !flagBIn));
      chk("R9 model padOut", padOut, (mHi[3:2] == 2'b11 && flagAIn) ? eCsr : mObuf);
      fa = flagExp(mHi[3:2], mObf);
      fb = flagExp(mHi[5:4], mIbf);
      chk("R10 model flagAOe", flagAOe, fa[1]);
      chk("R10 model flagBOe", flagBOe, fb[1]);
      if (fa[1]) chk("R10 model flagAOut", flagAOut, fa[0]);
      if (fb[1]) chk("R10 model flagBOut", flagBOut, fb[0]);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog (all R) got %0d cycles expected below 50000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    regSel = sel; regWdata = d; regWr = 1; step(1); regWr = 0;
  endtask

  task automatic rdBuf();
    regSel = 0; regRd = 1; step(1); regRd = 0;
  endtask

  task automatic chkCsr(string tag, logic [7:0] exp);
    regSel = 1; #1; chk(tag, regRdata, exp);
  endtask

  task automatic chkBuf(string tag, logic [7:0] exp);
    regSel = 0; #1; chk(tag, regRdata, exp);
  endtask

  initial begin
    step(3);
    rstN = 1; modelOn = 1;
    step(1);

    // R1 reset state
    chkCsr("R1 reset word", 8'hFC);
    chk("R1 drivers off", padOe, 0);
    chk("R1 flag A input", flagAOe, 0);
    chk("R1 flag B input", flagBOe, 0);

    // R2 read-only flag bits
    wr(1, 8'h03); chkCsr("R2 flags read-only", 8'h00);
    wr(1, 8'hFF); chkCsr("R2 restore", 8'hFC);

    // R3 output flag, rising clear
    wr(0, 8'hA5); chkCsr("R3 obf set", 8'hFE);
    outStbN = 0; step(4);
    chkCsr("R3 no clear on fall", 8'hFE);
    chk("R8 drive while strobe low", padOe, 1);
    chk("R9 buffer on pins", padOut, 8'hA5);
    outStbN = 1; step(4);
    chkCsr("R3 clear on rise", 8'hFC);
    // falling clear
    wr(1, 8'hF4); wr(0, 8'h5A); chkCsr("R3 obf set again", 8'hF6);
    outStbN = 0; step(4); chkCsr("R3 clear on fall", 8'hF4);
    outStbN = 1; step(4); chkCsr("R3 rise ignored", 8'hF4);
    // write coincides with clear edge
    wr(0, 8'h11);
    outStbN = 0; step(2);
    regSel = 0; regWdata = 8'h22; regWr = 1; step(1); regWr = 0;
    step(3);
    chkCsr("R3 write wins", 8'hF6);
    chk("R3 buffer from winning write", padOut, 8'h22);
    outStbN = 1; step(4);
    outStbN = 0; step(4); chkCsr("R3 clear after tie", 8'hF4);
    outStbN = 1; step(4);

    // R4 rising capture
    wr(1, 8'hF8);
    padIn = 8'h3C; inStbN = 0; step(4);
    chkCsr("R4 no set on fall", 8'hF8);
    chkBuf("R4 no load on fall", 8'h00);
    inStbN = 1; step(4);
    chkCsr("R4 set on rise", 8'hF9);
    chkBuf("R4 captured", 8'h3C);
    padIn = 8'h44; step(4);
    chkBuf("R4 holds", 8'h3C);

    // R6 read clears, capture wins tie
    rdBuf(); chkCsr("R6 read clears", 8'hF8);
    inStbN = 0; step(4);
    inStbN = 1; step(2);
    regSel = 0; regRd = 1; step(1); regRd = 0;
    step(2);
    chkCsr("R6 capture wins", 8'hF9);
    rdBuf(); chkCsr("R6 cleared", 8'hF8);

    // R5 transparent
    wr(1, 8'hFC);
    padIn = 8'h11; inStbN = 0; step(4);
    chkCsr("R5 set on fall", 8'hFD);
    chkBuf("R5 follows", 8'h11);
    padIn = 8'h22; step(4);
    chkBuf("R5 follows again", 8'h22);
    inStbN = 1; step(4);
    padIn = 8'h33; step(4);
    chkBuf("R5 holds high", 8'h22);
    rdBuf(); chkCsr("R5 cleared", 8'hFC);

    // R7 enable input high blocks strobe
    flagBIn = 1; step(4);
    outStbN = 0; step(1);
    chk("R8 gated by enable", padOe, 0);
    outStbN = 1;
    padIn = 8'h55; inStbN = 0; step(4);
    inStbN = 1; step(4);
    chkCsr("R7 flag untouched", 8'hFC);
    chkBuf("R7 buffer untouched", 8'h22);
    flagBIn = 0; step(4);

    // R8 output-always
    wr(1, 8'hBC);
    chk("R8 always on", padOe, 1);
    flagBIn = 1; step(1);
    chk("R8 enable pin no effect", padOe, 1);
    flagBIn = 0;
    wr(0, 8'h66); chkCsr("R8 obf set", 8'hBE);
    outStbN = 0; step(4); outStbN = 1; step(4);
    chkCsr("R8 strobe clears flag", 8'hBC);
    chk("R8 still driving", padOe, 1);

    // R9 status select
    wr(1, 8'hFC); wr(0, 8'hC3);
    flagAIn = 1; step(1);
    chk("R9 status on pins", padOut, 8'hFE);
    flagAIn = 0; step(1);
    chk("R9 buffer on pins", padOut, 8'hC3);

    // R10 flag pin modes
    wr(1, 8'h1C);
    chk("R10 A high oe", flagAOe, 1); chk("R10 A high", flagAOut, 1);
    chk("R10 B low oe", flagBOe, 1);  chk("R10 B low", flagBOut, 0);
    wr(1, 8'h4C);
    chk("R10 A low", flagAOut, 0); chk("R10 B high", flagBOut, 1);
    wr(1, 8'hAC);
    chk("R10 A mirrors obf", flagAOut, 1);
    chk("R10 B mirrors ibf", flagBOut, 0);
    padIn = 8'h77; inStbN = 0; step(4);
    chk("R10 B mirrors ibf set", flagBOut, 1);
    inStbN = 1; step(4);

    // R11 all control pins grounded
    rstN = 0;
    outStbN = 0; inStbN = 0; flagAIn = 0; flagBIn = 0; padIn = '0;
    step(2);
    rstN = 1; step(6);
    chk("R11 drivers on", padOe, 1);
    wr(0, 8'h77); step(1);
    chk("R11 write on pins", padOut, 8'h77);
    padIn = 8'h9A; step(4);
    chkBuf("R11 input follows", 8'h9A);
    chkCsr("R11 word", 8'hFF);

    step(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule